// File: doc/BRIEF.md
# Rounding and Saturation Unit

This block narrows a wide signed two's-complement value, typically the product or running sum of an arithmetic datapath, into a shorter signed output word. A runtime bit-position input, `lsb_pos`, selects which input bit becomes the least significant bit of the output. Every bit below that position is discarded. The discarded bits are either simply dropped or used to round the kept field, with the rounding rule chosen per sample.

After the shift and the optional rounding, the block can clamp the result to the signed range of the output word. The lower bound of that range is selectable between the full two's-complement minimum and its mirror of the maximum. When the rounded value does not fit and clamping is on, the block raises an overflow flag for that sample. Rounding is always applied before saturation. Each accepted sample appears at the output exactly one clock later.

Top module: `round_sat_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_data` is 0, and `out_valid` and `out_ovf` are low.
- R2: `out_valid` is high exactly one cycle after each cycle with `in_valid` high and low otherwise. `out_data` changes only one cycle after an accepted sample and holds its value across idle cycles.
- R3: With `rnd_en` = 0, the result is the input arithmetically shifted right by `lsb_pos`. This is floor division by 2^lsb_pos.
- R4: With `rnd_en` = 1 and `rnd_mode` = 0 (nearest integer), half an output LSB is added before truncation. An exact half therefore moves toward plus infinity: 0.5 gives 1, -0.5 gives 0, 2.5 gives 3.
- R5: With `rnd_en` = 1 and `rnd_mode` = 1 (nearest even), the kept field is incremented only when the discarded part is above one half, or exactly one half with the kept LSB equal to 1. So 0.5 gives 0, 1.5 gives 2, 2.5 gives 2, and -1.5 gives -2.
- R6: With `sat_en` = 1 and `sat_sym` = 0, results above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) are replaced by that bound, and `out_ovf` is high with that output.
- R7: With `sat_en` = 1 and `sat_sym` = 1, the lower bound is -(2^(OUT_W-1)-1). A result equal to -2^(OUT_W-1) is clamped to that bound and flags overflow.
- R8: Saturation acts on the rounded value. A rounding carry that lifts an in-range value past the maximum is clamped and flagged.
- R9: With `sat_en` = 0, the output is the low OUT_W bits of the rounded value, wrapping, and `out_ovf` stays low.
- R10: Values of `lsb_pos` above IN_W-OUT_W act as IN_W-OUT_W. With `lsb_pos` = 0, nothing is discarded and rounding has no effect.
- R11: `out_ovf` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for `in_data` and the controls |
| in_data | input | IN_W | Signed wide input value |
| lsb_pos | input | $clog2(IN_W) | Input bit that becomes the output LSB |
| rnd_en | input | 1 | 1 = round, 0 = truncate |
| rnd_mode | input | 1 | 0 = nearest integer, 1 = nearest even |
| sat_en | input | 1 | 1 = clamp to output range, 0 = wrap |
| sat_sym | input | 1 | 1 = symmetric lower bound |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | OUT_W | Signed rounded and saturated result |
| out_ovf | output | 1 | Clamping occurred for this result |

## Verification
Every result, including its overflow flag and valid strobe, is due in the cycle right after the rising edge that accepted the sample, since exactly one register stage lies on each path. The bench applies inputs on the falling edge, waits for one rising edge, and samples shortly after it. This means each comparison lands in that single result cycle. Idle cycles are sampled the same way to confirm that the valid strobe and the flag drop and that the data word holds.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

    typedef enum logic {
        RND_HALF_UP  = 1'b0,
        RND_HALF_EVEN = 1'b1
    } rnd_mode_e;

    typedef struct packed {
        logic      rnd_en;
        rnd_mode_e mode;
        logic      sat_en;
        logic      sat_sym;
    } rsu_cfg_t;

    // Decide whether the kept field is bumped by one.
    function automatic logic bump_needed(
        input rnd_mode_e mode,
        input logic      above_half,
        input logic      at_half,
        input logic      kept_lsb
    );
        if (mode == RND_HALF_EVEN)
            return above_half | (at_half & kept_lsb);
        else
            return above_half | at_half;
    endfunction

endpackage

// File: rtl/rsu_round.sv
module rsu_round
    import rsu_pkg::*;
#(
    parameter int IN_W  = 44,
    parameter int POS_W = 6
) (
    input  logic signed [IN_W-1:0]  din,
    input  logic        [POS_W-1:0] pos,
    input  logic                    rnd_en,
    input  rnd_mode_e               mode,
    output logic signed [IN_W:0]    q
);
    localparam int EW = IN_W + 1;
    localparam logic [EW-1:0] ONE = EW'(1);

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] shifted;
    logic        [EW-1:0] mask;
    logic        [EW-1:0] rem;
    logic        [EW-1:0] half;
    logic                 pos_nz;
    logic                 above, at, inc;

    always_comb begin
        ext     = {din[IN_W-1], din};
        shifted = ext >>> pos;
        mask    = (ONE << pos) - ONE;
        rem     = ext & mask;
        pos_nz  = (pos != '0);
        half    = pos_nz ? (ONE << (pos - POS_W'(1))) : '0;
        above   = pos_nz && (rem > half);
        at      = pos_nz && (rem == half);
        inc     = rnd_en & bump_needed(mode, above, at, shifted[0]);
        q       = shifted + $signed({{(EW-1){1'b0}}, inc});
    end

endmodule

// File: rtl/rsu_sat.sv
module rsu_sat #(
    parameter int IN_W  = 44,
    parameter int OUT_W = 18
) (
    input  logic signed [IN_W:0]    q,
    input  logic                    sat_en,
    input  logic                    sat_sym,
    output logic        [OUT_W-1:0] y,
    output logic                    ovf
);
    localparam int EW = IN_W + 1;
    localparam logic signed [EW-1:0] MAXV =
        $signed({{(EW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
    localparam logic signed [EW-1:0] MIN_FULL = -MAXV - EW'(1);
    localparam logic signed [EW-1:0] MIN_SYM  = -MAXV;

    logic signed [EW-1:0] lo;

    always_comb begin
        lo  = sat_sym ? MIN_SYM : MIN_FULL;
        y   = q[OUT_W-1:0];
        ovf = 1'b0;
        if (sat_en) begin
            if (q > MAXV) begin
                y   = MAXV[OUT_W-1:0];
                ovf = 1'b1;
            end else if (q < lo) begin
                y   = lo[OUT_W-1:0];
                ovf = 1'b1;
            end
        end
    end

endmodule

// File: rtl/round_sat_unit.sv
module round_sat_unit
    import rsu_pkg::*;
#(
    parameter int IN_W  = 44,
    parameter int OUT_W = 18,
    localparam int POS_W = $clog2(IN_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [IN_W-1:0]      in_data,
    input  logic [POS_W-1:0]     lsb_pos,
    input  logic                 rnd_en,
    input  logic                 rnd_mode,
    input  logic                 sat_en,
    input  logic                 sat_sym,
    output logic                 out_valid,
    output logic [OUT_W-1:0]     out_data,
    output logic                 out_ovf
);
    localparam int POS_MAX = IN_W - OUT_W;
    localparam logic [OUT_W-1:0] NEG_FULL = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] POS_TOP  = {1'b0, {(OUT_W-1){1'b1}}};

    rsu_cfg_t             cfg;
    logic [POS_W-1:0]     pos_eff;
    logic signed [IN_W:0] rounded;
    logic [OUT_W-1:0]     sat_y;
    logic                 sat_ovf;

    always_comb begin
        cfg.rnd_en  = rnd_en;
        cfg.mode    = rnd_mode_e'(rnd_mode);
        cfg.sat_en  = sat_en;
        cfg.sat_sym = sat_sym;
        pos_eff     = (lsb_pos > POS_W'(POS_MAX)) ? POS_W'(POS_MAX) : lsb_pos;
    end

    rsu_round #(.IN_W(IN_W), .POS_W(POS_W)) u_round (
        .din    ($signed(in_data)),
        .pos    (pos_eff),
        .rnd_en (cfg.rnd_en),
        .mode   (cfg.mode),
        .q      (rounded)
    );

    rsu_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat (
        .q       (rounded),
        .sat_en  (cfg.sat_en),
        .sat_sym (cfg.sat_sym),
        .y       (sat_y),
        .ovf     (sat_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ovf   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_ovf   <= in_valid & sat_ovf;
            if (in_valid)
                out_data <= sat_y;
        end
    end

    // R2: strobe follows accepted sample by one cycle
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2: data held over idle cycles
    p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    // R11: flag only with a valid result
    p_ovf_with_valid_r11: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> out_valid);
    // R9: no flag when clamping is off
    p_no_ovf_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !sat_en) |=> !out_ovf);
    // R6: flagged result sits on a bound
    p_ovf_on_bound_r6: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> (out_data == POS_TOP || out_data[OUT_W-1]));
    // R7: symmetric clamp never yields the full negative code
    p_sym_no_min_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && sat_sym) |=> (out_data != NEG_FULL));

endmodule

// File: tb/round_sat_unit_tb_top.sv
module round_sat_unit_tb_top;
    localparam int IN_W  = 44;
    localparam int OUT_W = 18;
    localparam int POS_W = $clog2(IN_W);
    localparam int POS_MAX = IN_W - OUT_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [IN_W-1:0]   in_data;
    logic [POS_W-1:0]  lsb_pos;
    logic              rnd_en, rnd_mode, sat_en, sat_sym;
    logic              out_valid;
    logic [OUT_W-1:0]  out_data;
    logic              out_ovf;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    round_sat_unit #(.IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
        .clk, .rst, .in_valid, .in_data, .lsb_pos, .rnd_en, .rnd_mode,
        .sat_en, .sat_sym, .out_valid, .out_data, .out_ovf
    );

    function automatic void model(
        input  logic [IN_W-1:0] d, input int p_in,
        input  bit ren, input bit rm, input bit sen, input bit ssym,
        output logic [OUT_W-1:0] y, output bit ov
    );
        longint x, sh, rem, half, q, mx, mn;
        int p;
        bit inc;
        x    = longint'($signed({{(64-IN_W){d[IN_W-1]}}, d}));
        p    = (p_in > POS_MAX) ? POS_MAX : p_in;
        sh   = x >>> p;
        rem  = x - (sh <<< p);
        half = (p > 0) ? (64'sd1 <<< (p - 1)) : 64'sd0;
        inc  = 1'b0;
        if (ren && p > 0)
            inc = rm ? ((rem > half) || (rem == half && sh[0])) : (rem >= half);
        q  = sh + longint'(inc);
        mx = (64'sd1 <<< (OUT_W - 1)) - 1;
        mn = ssym ? -mx : -mx - 1;
        ov = 1'b0;
        if (sen && q > mx) begin q = mx; ov = 1'b1; end
        else if (sen && q < mn) begin q = mn; ov = 1'b1; end
        y = q[OUT_W-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Apply one sample and check its result in the following cycle.
    task automatic run(input string req, input longint x, input int p,
                       input bit ren, input bit rm, input bit sen, input bit ssym);
        logic [OUT_W-1:0] ey;
        bit eo;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x[IN_W-1:0];
        lsb_pos  = POS_W'(p);
        rnd_en = ren; rnd_mode = rm; sat_en = sen; sat_sym = ssym;
        model(x[IN_W-1:0], p, ren, rm, sen, ssym, ey, eo);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        chk(out_valid === 1'b1, req, "valid", longint'(out_valid), 1);
        chk(out_data === ey, req, "data", longint'($signed(out_data)), longint'($signed(ey)));
        chk(out_ovf === eo, req, "ovf", longint'(out_ovf), longint'(eo));
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [OUT_W-1:0] held;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; in_valid = 1'b0; in_data = '0; lsb_pos = '0;
        rnd_en = 1'b0; rnd_mode = 1'b0; sat_en = 1'b0; sat_sym = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(out_data === '0, "R1", "reset data", longint'(out_data), 0);
        chk(out_valid === 1'b0, "R1", "reset valid", longint'(out_valid), 0);
        chk(out_ovf === 1'b0, "R1", "reset ovf", longint'(out_ovf), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk(out_valid === 1'b0 && out_data === '0, "R1", "post-reset",
            longint'(out_data), 0);

        // R3 truncation
        run("R3", -64'sd9, 2, 0, 0, 0, 0);
        run("R3", 64'sd1000, 3, 0, 0, 1, 0);
        // R4 nearest integer ties
        run("R4", 64'sd8, 4, 1, 0, 1, 0);
        run("R4", -64'sd8, 4, 1, 0, 1, 0);
        run("R4", 64'sd40, 4, 1, 0, 1, 0);
        run("R4", -64'sd24, 4, 1, 0, 1, 0);
        // R5 nearest even ties
        run("R5", 64'sd8, 4, 1, 1, 1, 0);
        run("R5", 64'sd24, 4, 1, 1, 1, 0);
        run("R5", 64'sd40, 4, 1, 1, 1, 0);
        run("R5", -64'sd24, 4, 1, 1, 1, 0);
        run("R5", 64'sd41, 4, 1, 1, 1, 0);
        // R6 asymmetric clamp
        run("R6", 64'sd1 <<< 30, 4, 0, 0, 1, 0);
        run("R6", -(64'sd1 <<< 30), 4, 0, 0, 1, 0);
        run("R6", -(64'sd131072 <<< 4), 4, 0, 0, 1, 0);
        // R7 symmetric clamp, exact full minimum
        run("R7", -(64'sd131072 <<< 4), 4, 0, 0, 1, 1);
        run("R7", -(64'sd1 <<< 40), 10, 1, 1, 1, 1);
        // R8 round carry pushes past maximum
        run("R8", (64'sd131071 <<< 4) + 8, 4, 1, 0, 1, 0);
        run("R8", (64'sd131071 <<< 4) + 8, 4, 1, 0, 0, 0);
        // R9 wrap without clamp
        run("R9", 64'sd131072 <<< 4, 4, 0, 0, 0, 0);
        // R10 position clamp and zero position
        run("R10", 64'sd1 <<< 35, 40, 1, 0, 1, 0);
        run("R10", -64'sd5, 0, 1, 0, 1, 0);
        run("R10", 64'sd100, POS_MAX, 1, 1, 1, 1);

        // R2/R11 idle: strobe and flag low, data held
        held = out_data;
        @(posedge clk); #1;
        chk(out_valid === 1'b0, "R2", "idle valid", longint'(out_valid), 0);
        chk(out_data === held, "R2", "idle hold", longint'(out_data), longint'(held));
        chk(out_ovf === 1'b0, "R11", "idle ovf", longint'(out_ovf), 0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [63:0] r;
            longint x;
            int sh;
            r  = {$urandom, $urandom};
            sh = $urandom_range(IN_W - 1, 8);
            x  = longint'($signed(r)) >>> (64 - sh);
            run("R3", x, $urandom_range(POS_MAX, 0), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule